// File: doc/BRIEF.md
# Programmable AND-OR Term Array with Shared Term Steering

This block is the combinational logic core of one programmable logic block. A bus of 36 interconnect signals enters and is expanded into 72 array columns, one true and one inverted copy of each signal. Every one of 86 product terms is the logical AND of the columns its connection mask selects. A steering stage then builds 16 macrocell sums, each the OR of the product terms enabled for that macrocell. Any macrocell may take from zero up to sixteen terms, and one term may drive several macrocells at once, so logic that several outputs share needs only one product term.

The connection masks and the per-macrocell selection vectors sit in configuration registers loaded through a single synchronous write port. The path from the input bus to the sums has no register in it, so the sums follow the inputs within the same cycle. The port refuses a selection vector with more than sixteen enabled terms and keeps the previous selection in place.

Top module: `pta_block`

## Requirements
- R1: Array column c for c in 0..35 carries in_i[c], and column 36+c carries the inverse of in_i[c]. A product term equals the AND of the columns whose bit is set in its 72-bit mask.
- R2: A product term whose mask has no bit set evaluates to 0 for every input value.
- R3: sum_o[m] equals the OR of the product terms p whose bit p is set in the 86-bit selection vector of macrocell m.
- R4: One product term enabled in the selection vectors of several macrocells drives all of those sums at the same time.
- R5: A selection vector with no bit set gives a constant 0 sum. A vector with exactly 16 bits set is accepted.
- R6: A selection write whose vector has more than 16 bits set is refused, and that macrocell keeps its earlier selection.
- R7: The write port works as follows. When cfg_we is high at a rising clk edge, cfg_kind 0 writes cfg_data[71:0] as the mask of term cfg_idx, and cfg_kind 1 writes cfg_data[85:0] as the selection vector of macrocell cfg_idx. The new value acts on sum_o right after that edge. A write with cfg_idx of 86 or more for a mask, or 16 or more for a selection, is ignored.
- R8: While rst_n is low, all masks and selection vectors clear, so every sum is 0.
- R9: sum_o responds to a change on in_i without any clock edge, and stays constant while in_i and the configuration stay constant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Asynchronous active-low reset that clears the configuration |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 1 | 0 selects a term mask, 1 selects a macrocell selection vector |
| cfg_idx | input | 7 | Term index or macrocell index to write |
| cfg_data | input | 86 | Mask in the low 72 bits, or the selection vector |
| in_i | input | 36 | Signals from the interconnect |
| sum_o | output | 16 | Macrocell sum outputs |

## Verification
There is no pipeline, so a corrupted mask or selection bit shows on sum_o in the first cycle after the write that caused it. It shows only under an input pattern that makes the affected term true, or makes it the only true term in a sum. A selection vector that was refused but stored anyway, or a write to an out-of-range index that aliases onto a real entry, changes a sum only for those same patterns. For this reason the directed cases put in place the one input value that exposes each fault, and random masks with few literals keep terms firing often enough for random patterns to reach the rest.

// File: rtl/pta_pkg.sv
package pta_pkg;
    localparam int unsigned PTA_IN    = 36;
    localparam int unsigned PTA_TERMS = 86;
    localparam int unsigned PTA_MC    = 16;
    localparam int unsigned PTA_MAXPT = 16;

    typedef enum logic {
        CFG_MASK = 1'b0,
        CFG_SEL  = 1'b1
    } cfg_kind_e;
endpackage

// File: rtl/pta_cfg_store.sv
module pta_cfg_store #(
    parameter int unsigned N_IN    = 36,
    parameter int unsigned N_TERMS = 86,
    parameter int unsigned N_MC    = 16,
    parameter int unsigned MAX_PT  = 16,
    parameter int unsigned IDX_W   = 7,
    parameter int unsigned DATA_W  = 86
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             cfg_we,
    input  logic                             cfg_kind,
    input  logic [IDX_W-1:0]                 cfg_idx,
    input  logic [DATA_W-1:0]                cfg_data,
    output logic [N_TERMS-1:0][2*N_IN-1:0]   mask_o,
    output logic [N_MC-1:0][N_TERMS-1:0]     sel_o
);
    import pta_pkg::*;

    localparam int unsigned COLS = 2 * N_IN;

    typedef struct packed {
        logic [N_TERMS-1:0][COLS-1:0]   mask;
        logic [N_MC-1:0][N_TERMS-1:0]   sel;
    } cfg_state_t;

    cfg_state_t st_d, st_q;
    logic [N_TERMS-1:0] sel_wr;
    logic [COLS-1:0]    mask_wr;
    logic               sel_fits;

    assign sel_wr   = cfg_data[N_TERMS-1:0];
    assign mask_wr  = cfg_data[COLS-1:0];
    assign sel_fits = ($countones(sel_wr) <= MAX_PT);

    always_comb begin
        st_d = st_q;
        if (cfg_we) begin
            if (cfg_kind == CFG_MASK) begin
                if (32'(cfg_idx) < N_TERMS) begin
                    st_d.mask[cfg_idx] = mask_wr;
                end
            end else begin
                if ((32'(cfg_idx) < N_MC) && sel_fits) begin
                    st_d.sel[cfg_idx] = sel_wr;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mask_o = st_q.mask;
    assign sel_o  = st_q.sel;
endmodule

// File: rtl/pta_and_plane.sv
module pta_and_plane #(
    parameter int unsigned N_IN    = 36,
    parameter int unsigned N_TERMS = 86
) (
    input  logic [N_IN-1:0]                in_i,
    input  logic [N_TERMS-1:0][2*N_IN-1:0] mask_i,
    output logic [N_TERMS-1:0]             term_o
);
    localparam int unsigned COLS = 2 * N_IN;

    logic [COLS-1:0] cols;
    assign cols = {~in_i, in_i};

    for (genvar p = 0; p < N_TERMS; p++) begin : g_term
        logic used;
        logic all_hit;
        assign used    = |mask_i[p];
        assign all_hit = &(~mask_i[p] | cols);
        assign term_o[p] = used & all_hit;
    end
endmodule

// File: rtl/pta_or_plane.sv
module pta_or_plane #(
    parameter int unsigned N_TERMS = 86,
    parameter int unsigned N_MC    = 16
) (
    input  logic [N_TERMS-1:0]           term_i,
    input  logic [N_MC-1:0][N_TERMS-1:0] sel_i,
    output logic [N_MC-1:0]              sum_o
);
    for (genvar m = 0; m < N_MC; m++) begin : g_mc
        assign sum_o[m] = |(term_i & sel_i[m]);
    end
endmodule

// File: rtl/pta_block.sv
module pta_block #(
    parameter int unsigned N_IN    = pta_pkg::PTA_IN,
    parameter int unsigned N_TERMS = pta_pkg::PTA_TERMS,
    parameter int unsigned N_MC    = pta_pkg::PTA_MC,
    parameter int unsigned MAX_PT  = pta_pkg::PTA_MAXPT,
    parameter int unsigned IDX_W   = $clog2(N_TERMS),
    parameter int unsigned DATA_W  = (2 * N_IN > N_TERMS) ? 2 * N_IN : N_TERMS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_kind,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [DATA_W-1:0] cfg_data,
    input  logic [N_IN-1:0]   in_i,
    output logic [N_MC-1:0]   sum_o
);
    logic [N_TERMS-1:0][2*N_IN-1:0] mask;
    logic [N_MC-1:0][N_TERMS-1:0]   sel;
    logic [N_TERMS-1:0]             terms;

    pta_cfg_store #(
        .N_IN(N_IN), .N_TERMS(N_TERMS), .N_MC(N_MC),
        .MAX_PT(MAX_PT), .IDX_W(IDX_W), .DATA_W(DATA_W)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
        .cfg_idx(cfg_idx), .cfg_data(cfg_data), .mask_o(mask), .sel_o(sel)
    );

    pta_and_plane #(.N_IN(N_IN), .N_TERMS(N_TERMS)) u_and (
        .in_i(in_i), .mask_i(mask), .term_o(terms)
    );

    pta_or_plane #(.N_TERMS(N_TERMS), .N_MC(N_MC)) u_or (
        .term_i(terms), .sel_i(sel), .sum_o(sum_o)
    );
endmodule

// File: rtl/pta_block_chk.sv
module pta_block_chk #(
    parameter int unsigned N_IN    = 36,
    parameter int unsigned N_TERMS = 86,
    parameter int unsigned N_MC    = 16,
    parameter int unsigned MAX_PT  = 16,
    parameter int unsigned IDX_W   = 7,
    parameter int unsigned DATA_W  = 86
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic              cfg_kind,
    input logic [IDX_W-1:0]  cfg_idx,
    input logic [DATA_W-1:0] cfg_data,
    input logic [N_IN-1:0]   in_i,
    input logic [N_MC-1:0]   sum_o
);
    localparam int unsigned MC_W = $clog2(N_MC);

    logic over_wr, empty_wr, range_bad;
    assign over_wr   = cfg_we && cfg_kind && ($countones(cfg_data[N_TERMS-1:0]) > MAX_PT);
    assign empty_wr  = cfg_we && cfg_kind && (32'(cfg_idx) < N_MC) && (cfg_data[N_TERMS-1:0] == '0);
    assign range_bad = cfg_we && (cfg_kind ? (32'(cfg_idx) >= N_MC) : (32'(cfg_idx) >= N_TERMS));

    // R6
    over_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        over_wr |=> (in_i != $past(in_i)) || $stable(sum_o));

    // R5
    empty_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        empty_wr |=> sum_o[$past(cfg_idx[MC_W-1:0])] == 1'b0);

    // R7
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        range_bad |=> (in_i != $past(in_i)) || $stable(sum_o));

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_i == $past(in_i)) && !$past(cfg_we) |-> $stable(sum_o));

    // R8
    reset_clear_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> sum_o == '0);
endmodule

bind pta_block pta_block_chk #(
    .N_IN(N_IN), .N_TERMS(N_TERMS), .N_MC(N_MC),
    .MAX_PT(MAX_PT), .IDX_W(IDX_W), .DATA_W(DATA_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
    .cfg_idx(cfg_idx), .cfg_data(cfg_data), .in_i(in_i), .sum_o(sum_o)
);

// File: tb/pta_block_tb.sv
module pta_block_tb;
    localparam int NI = 36;
    localparam int NT = 86;
    localparam int NM = 16;
    localparam int NC = 72;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic          cfg_kind = 1'b0;
    logic [6:0]    cfg_idx = '0;
    logic [85:0]   cfg_data = '0;
    logic [NI-1:0] in_i = '0;
    logic [NM-1:0] sum_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [NC-1:0] m_mask [NT];
    logic [NT-1:0] m_sel  [NM];

    always #2.5 clk = ~clk;

    pta_block u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
        .cfg_idx(cfg_idx), .cfg_data(cfg_data), .in_i(in_i), .sum_o(sum_o)
    );

    function automatic logic [NM-1:0] model_sum(logic [NI-1:0] x);
        logic [NC-1:0] cols;
        logic [NT-1:0] pt;
        logic [NM-1:0] s;
        cols = {~x, x};
        for (int p = 0; p < NT; p++)
            pt[p] = (m_mask[p] != '0) && ((~m_mask[p] | cols) == '1);
        for (int m = 0; m < NM; m++)
            s[m] = |(pt & m_sel[m]);
        return s;
    endfunction

    task automatic chk(string req, logic [NM-1:0] act, logic [NM-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: sum_o=%h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(bit kind, int idx, logic [85:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_kind = kind; cfg_idx = 7'(idx); cfg_data = data;
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
        if (kind == 1'b0 && idx < NT) m_mask[idx] = data[NC-1:0];
        if (kind == 1'b1 && idx < NM && $countones(data) <= 16) m_sel[idx] = data;
        #1;
    endtask

    task automatic drive(logic [NI-1:0] x);
        in_i = x;
        #1;
    endtask

    function automatic logic [NI-1:0] rnd_in();
        return {4'($urandom), $urandom};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run did not finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [85:0] v;
        void'($urandom(32'h5eed1234));
        for (int p = 0; p < NT; p++) m_mask[p] = '0;
        for (int m = 0; m < NM; m++) m_sel[m] = '0;
        in_i = 36'hF0F0_F0F0F;
        repeat (3) @(posedge clk);
        #1;
        chk("R8 reset", sum_o, '0);
        @(negedge clk); rst_n = 1'b1;
        #1;
        chk("R8 after release", sum_o, '0);

        // R1: term 0 = in[0] & ~in[1]
        wr(1'b0, 0, 86'(72'h0_0000_0002 << 36 | 72'h1));
        wr(1'b1, 0, 86'h1);
        drive(36'h1);
        chk("R1 literal pair true", sum_o, 16'h0001);
        drive(36'h3);
        chk("R1 complement literal blocks", sum_o, 16'h0000);
        // R9: no clock between change and sample
        @(negedge clk);
        in_i = 36'h1; #0.5;
        chk("R9 combinational response", sum_o, 16'h0001);
        #0.5;

        // R4 sharing
        wr(1'b1, 1, 86'h1);
        chk("R4 shared term drives two sums", sum_o, 16'h0003);
        chk("R3 model compare", sum_o, model_sum(in_i));

        // R2 erased term
        wr(1'b0, 0, 86'h0);
        drive('0);
        chk("R2 empty mask all zero in", sum_o, 16'h0000);
        drive('1);
        chk("R2 empty mask all one in", sum_o, 16'h0000);

        // terms 1..17 = in[0]
        for (int p = 1; p <= 17; p++) wr(1'b0, p, 86'h1);
        v = '0;
        for (int p = 1; p <= 16; p++) v[p] = 1'b1;
        wr(1'b1, 2, v);
        drive(36'h1);
        chk("R5 sixteen terms accepted", sum_o, 16'h0004);
        v[17] = 1'b1;
        wr(1'b1, 3, v);
        chk("R6 seventeen terms refused", sum_o, 16'h0004);
        wr(1'b1, 2, v);
        chk("R6 refused write keeps old selection", sum_o, 16'h0004);
        wr(1'b1, 2, 86'h0);
        chk("R5 empty selection gives zero", sum_o, 16'h0000);

        // R7 out-of-range selection index (would alias to 4)
        wr(1'b1, 20, 86'h2);
        chk("R7 out-of-range selection ignored", sum_o, 16'h0000);
        wr(1'b0, 100, 86'h0);
        wr(1'b1, 5, 86'h2);
        chk("R7 in-range selection after ignored writes", sum_o, 16'h0020);

        // random programming
        for (int p = 0; p < NT; p++) begin
            logic [NC-1:0] mk = '0;
            int nl = 1 + int'($urandom % 3);
            for (int k = 0; k < nl; k++) mk[$urandom % NC] = 1'b1;
            if ($urandom % 10 == 0) mk = '0;
            wr(1'b0, p, 86'(mk));
        end
        for (int m = 0; m < NM; m++) begin
            int cnt = int'($urandom % 17);
            v = '0;
            for (int k = 0; k < cnt; k++) v[$urandom % NT] = 1'b1;
            wr(1'b1, m, v);
        end
        for (int it = 0; it < 400; it++) begin
            if (it % 40 == 39) begin
                v = '0;
                for (int k = 0; k < 17 + int'($urandom % 10); k++) v[k * 3] = 1'b1;
                wr(1'b1, int'($urandom % NM), v);
                chk("R6 random oversize refused", sum_o, model_sum(in_i));
            end else if (it % 10 == 9) begin
                int cnt = int'($urandom % 17);
                v = '0;
                for (int k = 0; k < cnt; k++) v[$urandom % NT] = 1'b1;
                wr(1'b1, int'($urandom % NM), v);
                chk("R3 after selection rewrite", sum_o, model_sum(in_i));
            end
            drive(rnd_in());
            chk("R3 random inputs", sum_o, model_sum(in_i));
        end

        // R8 reset mid-run
        @(negedge clk); rst_n = 1'b0; #1;
        for (int p = 0; p < NT; p++) m_mask[p] = '0;
        for (int m = 0; m < NM; m++) m_sel[m] = '0;
        chk("R8 reset clears configuration", sum_o, '0);
        @(negedge clk); rst_n = 1'b1; #1;

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule